// File: doc/BRIEF.md
# Self-programming command sequencer

This block holds the control and status register through which software starts flash self-programming. Software writes a command byte. The command only takes effect if a separate execute strobe follows within a short window. When the strobe arrives in time, the block decodes the command and starts one of five actions: erase a page, write a page, load one word into the page buffer, write the lock byte, or re-open the read-while-write region.

The page number and word index come from a 16-bit byte pointer plus one extension bit. Long operations stop the processor if they target the protected top region. If they target the lower region, they set a sticky busy flag instead, and that flag stays set until software re-opens the region. A level interrupt is driven whenever the block is enabled for interrupts and has no command pending. The flash array is modelled by an internal timer that produces a completion pulse a fixed number of cycles after the start.

Top module: `selfprog_seq`

## Requirements
- R1: A register write with bit 0 (enable) set opens a window of WINDOW (4) clocks. The strobe is accepted when it is sampled on any of the 4 rising edges that follow the write edge. If no strobe arrives by the 4th edge, bit 0 and bits 4:1 read 0 after that edge.
- R2: The command byte layout is as follows. Bit 0 is enable, bit 1 is erase, bit 2 is write, bit 3 is lock set and bit 4 is re-open. Bit 7 is the interrupt enable, and it reads back as written. Bit 6 reads the region-busy flag and bit 5 reads 0. The valid command bits 4:1 are 0000 (buffer load), 0001 (erase), 0010 (write), 0100 (lock) and 1000 (re-open). A write with bit 0 clear stores bits 4:1 as 0.
- R3: An accepted erase (flash_kind 01) or write (flash_kind 10) pulses flash_go for one cycle, with flash_page = {zext, zptr[15:8]}. The command is rejected if zptr[7:0] is nonzero.
- R4: An accepted buffer load pulses buf_we for one cycle, with buf_index = zptr[7:1] and buf_data = data_word. Bit 0 reads 0 during that pulse.
- R5: An accepted lock write pulses flash_go with flash_kind 11 and lock_bits = data_word[7:0]. It does not touch the busy flag or the halt output.
- R6: An erase or write to a page below NRWW_PAGE (480) sets bit 6 and rww_busy. Both stay set until an accepted re-open command clears them.
- R7: An erase or write to a page at or above NRWW_PAGE holds cpu_halt high from the start edge until the operation completes.
- R8: irq is high exactly while bit 7 is 1 and bit 0 is 0.
- R9: A register write made while eep_busy is high changes nothing.
- R10: After an erase, write or lock is accepted, bit 0 reads 1 for exactly OP_CYCLES cycles. flash_done is high in the last of them, and bit 0 reads 0 from the next edge on.
- R11: A strobe with bit 0 clear, a strobe after the window, or a strobe for an invalid command has no effect. flash_go and buf_we stay low.
- R12: After reset the register reads 0x00, and irq, cpu_halt, rww_busy, flash_go and buf_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Control register write |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register read value |
| zptr | input | 16 | Byte pointer |
| zext | input | 1 | Pointer extension bit (address bit 16) |
| data_word | input | 16 | Data word for buffer load or lock byte |
| spm_strobe | input | 1 | Execute strobe |
| eep_busy | input | 1 | EEPROM write in progress |
| buf_we | output | 1 | Page-buffer word write pulse |
| buf_index | output | 7 | Page-buffer word index |
| buf_data | output | 16 | Page-buffer word data |
| flash_go | output | 1 | Flash operation start pulse |
| flash_kind | output | 2 | 01 erase, 10 write, 11 lock |
| flash_page | output | 9 | Target page |
| lock_bits | output | 8 | Lock byte to program |
| flash_done | output | 1 | Modelled completion pulse |
| cpu_halt | output | 1 | Processor halt request |
| rww_busy | output | 1 | Read-while-write region blocked |
| irq | output | 1 | Idle level interrupt |

## Verification
A window counter stuck open or closed shows up at the edge after the fourth clock: either bit 0 is still high there, or a strobe that should have been accepted produces no start pulse. A wrong decode or region compare is visible in the same cycle as the start pulse, through flash_kind, flash_page, cpu_halt and bit 6. A bad operation timer changes the number of cycles that bit 0 stays high, and that error appears within OP_CYCLES cycles. A lost or false busy flag shows up on the read value right after the start pulse, or after the re-open command.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  typedef enum logic [1:0] {
    FK_NONE  = 2'b00,
    FK_ERASE = 2'b01,
    FK_WRITE = 2'b10,
    FK_LOCK  = 2'b11
  } flash_kind_e;

  typedef enum logic [2:0] {
    CMD_LOAD,
    CMD_ERASE,
    CMD_WRITE,
    CMD_LOCK,
    CMD_REOPEN,
    CMD_BAD
  } cmd_e;
endpackage

// File: rtl/selfprog_window.sv
module selfprog_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cancel,
  output logic open_o,
  output logic last_o
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm)                cnt_d = CW'(WINDOW);
    else if (cancel)        cnt_d = '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign open_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/selfprog_decode.sv
module selfprog_decode
  import selfprog_pkg::*;
#(
  parameter int PAGE_W    = 9,
  parameter int NRWW_PAGE = 480
) (
  input  logic [3:0]        cmd_bits,
  input  logic              zext,
  input  logic [15:0]       zptr,
  output cmd_e              cmd,
  output logic [PAGE_W-1:0] page,
  output logic              in_nrww
);
  logic sub_page_zero;

  assign page          = PAGE_W'({zext, zptr[15:8]});
  assign sub_page_zero = (zptr[7:0] == 8'h00);
  assign in_nrww       = (page >= PAGE_W'(NRWW_PAGE));

  always_comb begin
    unique case (cmd_bits)
      4'b0000: cmd = CMD_LOAD;
      4'b0001: cmd = sub_page_zero ? CMD_ERASE : CMD_BAD;
      4'b0010: cmd = sub_page_zero ? CMD_WRITE : CMD_BAD;
      4'b0100: cmd = CMD_LOCK;
      4'b1000: cmd = CMD_REOPEN;
      default: cmd = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/selfprog_optimer.sv
module selfprog_optimer #(
  parameter int CYCLES = 65600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
#(
  parameter int WINDOW    = 4,
  parameter int OP_CYCLES = 65600,
  parameter int NRWW_PAGE = 480
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [7:0]  csr_wdata,
  output logic [7:0]  csr_rdata,
  input  logic [15:0] zptr,
  input  logic        zext,
  input  logic [15:0] data_word,
  input  logic        spm_strobe,
  input  logic        eep_busy,
  output logic        buf_we,
  output logic [6:0]  buf_index,
  output logic [15:0] buf_data,
  output logic        flash_go,
  output logic [1:0]  flash_kind,
  output logic [8:0]  flash_page,
  output logic [7:0]  lock_bits,
  output logic        flash_done,
  output logic        cpu_halt,
  output logic        rww_busy,
  output logic        irq
);
  localparam int PAGE_W = 9;

  logic              en_q, en_d;
  logic [3:0]        cmd_q, cmd_d;
  logic              ie_q, ie_d;
  logic              rww_q, rww_d;
  logic              halt_q, halt_d;
  logic              go_q, go_d;
  flash_kind_e       kind_q, kind_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [7:0]        lock_q, lock_d;
  logic              bwe_q, bwe_d;
  logic [6:0]        bidx_q, bidx_d;
  logic [15:0]       bdat_q, bdat_d;

  logic              run, op_done, win_open, win_last;
  logic              wr_ok, accept, timeout, long_start;
  cmd_e              dec_cmd;
  logic [PAGE_W-1:0] dec_page;
  logic              dec_nrww;

  assign wr_ok   = csr_we && !eep_busy && !run;
  assign accept  = spm_strobe && en_q && !run && win_open && !wr_ok;
  assign timeout = win_last && en_q && !run && !accept && !wr_ok;
  assign long_start = accept &&
    (dec_cmd == CMD_ERASE || dec_cmd == CMD_WRITE || dec_cmd == CMD_LOCK);

  selfprog_decode #(.PAGE_W(PAGE_W), .NRWW_PAGE(NRWW_PAGE)) u_decode (
    .cmd_bits (cmd_q),
    .zext     (zext),
    .zptr     (zptr),
    .cmd      (dec_cmd),
    .page     (dec_page),
    .in_nrww  (dec_nrww)
  );

  selfprog_window #(.WINDOW(WINDOW)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (wr_ok && csr_wdata[0]),
    .cancel (accept || wr_ok),
    .open_o (win_open),
    .last_o (win_last)
  );

  selfprog_optimer #(.CYCLES(OP_CYCLES)) u_optimer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (long_start),
    .busy  (run),
    .done  (op_done)
  );

  always_comb begin
    en_d   = en_q;
    cmd_d  = cmd_q;
    ie_d   = ie_q;
    rww_d  = rww_q;
    halt_d = halt_q;
    kind_d = kind_q;
    page_d = page_q;
    lock_d = lock_q;
    bidx_d = bidx_q;
    bdat_d = bdat_q;
    go_d   = 1'b0;
    bwe_d  = 1'b0;

    if (wr_ok) begin
      ie_d  = csr_wdata[7];
      en_d  = csr_wdata[0];
      cmd_d = csr_wdata[0] ? csr_wdata[4:1] : 4'b0000;
    end else if (accept) begin
      unique case (dec_cmd)
        CMD_LOAD: begin
          bwe_d  = 1'b1;
          bidx_d = zptr[7:1];
          bdat_d = data_word;
          en_d   = 1'b0;
          cmd_d  = 4'b0000;
        end
        CMD_ERASE, CMD_WRITE: begin
          go_d   = 1'b1;
          kind_d = (dec_cmd == CMD_ERASE) ? FK_ERASE : FK_WRITE;
          page_d = dec_page;
          if (dec_nrww) halt_d = 1'b1;
          else          rww_d  = 1'b1;
        end
        CMD_LOCK: begin
          go_d   = 1'b1;
          kind_d = FK_LOCK;
          lock_d = data_word[7:0];
        end
        CMD_REOPEN: begin
          rww_d = 1'b0;
          en_d  = 1'b0;
          cmd_d = 4'b0000;
        end
        default: begin
          en_d  = 1'b0;
          cmd_d = 4'b0000;
        end
      endcase
    end else if (timeout) begin
      en_d  = 1'b0;
      cmd_d = 4'b0000;
    end

    if (op_done) begin
      en_d   = 1'b0;
      cmd_d  = 4'b0000;
      halt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cmd_q  <= 4'b0000;
      ie_q   <= 1'b0;
      rww_q  <= 1'b0;
      halt_q <= 1'b0;
      go_q   <= 1'b0;
      kind_q <= FK_NONE;
      page_q <= '0;
      lock_q <= 8'hFF;
      bwe_q  <= 1'b0;
      bidx_q <= '0;
      bdat_q <= '0;
    end else begin
      en_q   <= en_d;
      cmd_q  <= cmd_d;
      ie_q   <= ie_d;
      rww_q  <= rww_d;
      halt_q <= halt_d;
      go_q   <= go_d;
      kind_q <= kind_d;
      page_q <= page_d;
      lock_q <= lock_d;
      bwe_q  <= bwe_d;
      bidx_q <= bidx_d;
      bdat_q <= bdat_d;
    end
  end

  assign csr_rdata  = {ie_q, rww_q, 1'b0, cmd_q, en_q};
  assign buf_we     = bwe_q;
  assign buf_index  = bidx_q;
  assign buf_data   = bdat_q;
  assign flash_go   = go_q;
  assign flash_kind = kind_q;
  assign flash_page = page_q;
  assign lock_bits  = lock_q;
  assign flash_done = op_done;
  assign cpu_halt   = halt_q;
  assign rww_busy   = rww_q;
  assign irq        = ie_q && !en_q;
endmodule

// File: rtl/selfprog_seq_chk.sv
module selfprog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csr_we,
  input logic       eep_busy,
  input logic [7:0] csr_rdata,
  input logic       irq,
  input logic       flash_go,
  input logic       flash_done,
  input logic       buf_we,
  input logic       cpu_halt
);
  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!csr_rdata[0] && csr_rdata[7]));

  assert_go_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_go |-> csr_rdata[0]);

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_done |=> !csr_rdata[0]);

  assert_halt_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> csr_rdata[0]);

  assert_load_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !csr_rdata[0]);

  assert_single_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_go, buf_we}));

  assert_eeprom_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eep_busy && csr_we && !csr_rdata[0]) |=> $stable(csr_rdata));

  assert_no_self_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rdata[0] && !csr_we) |=> !csr_rdata[0]);
endmodule

bind selfprog_seq selfprog_seq_chk u_chk (.*);

// File: tb/selfprog_seq_bench.sv
module selfprog_seq_bench;
  localparam int OPC = 24;

  logic        clk, rst_n;
  logic        csr_we;
  logic [7:0]  csr_wdata, csr_rdata;
  logic [15:0] zptr, data_word, buf_data;
  logic        zext, spm_strobe, eep_busy;
  logic        buf_we, flash_go, flash_done, cpu_halt, rww_busy, irq;
  logic [6:0]  buf_index;
  logic [1:0]  flash_kind;
  logic [8:0]  flash_page;
  logic [7:0]  lock_bits;

  int n_chk = 0;
  int n_bad = 0;

  selfprog_seq #(.WINDOW(4), .OP_CYCLES(OPC), .NRWW_PAGE(480)) u_selfprog_seq (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .zptr(zptr), .zext(zext), .data_word(data_word),
    .spm_strobe(spm_strobe), .eep_busy(eep_busy), .buf_we(buf_we),
    .buf_index(buf_index), .buf_data(buf_data), .flash_go(flash_go),
    .flash_kind(flash_kind), .flash_page(flash_page), .lock_bits(lock_bits),
    .flash_done(flash_done), .cpu_halt(cpu_halt), .rww_busy(rww_busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  wdata;
    logic        zx;
    logic [15:0] z;
    logic [15:0] data;
    logic [2:0]  dly;
    logic        go;
    logic [1:0]  kind;
    logic        halt;
    logic        bufw;
    logic        rww;
    logic [8:0]  page;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h03, 1'b0, 16'h0500, 16'h0000, 3'd1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 9'd5},
    '{8'h05, 1'b1, 16'hE000, 16'h0000, 3'd4, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 9'd480},
    '{8'h01, 1'b0, 16'h0006, 16'h1234, 3'd2, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 9'd0},
    '{8'h09, 1'b0, 16'h0001, 16'h00CF, 3'd3, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 9'd0},
    '{8'h03, 1'b0, 16'h0502, 16'h0000, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 9'd0},
    '{8'h07, 1'b0, 16'h0500, 16'h0000, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 9'd0},
    '{8'h03, 1'b0, 16'h0500, 16'h0000, 3'd5, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 9'd0},
    '{8'h83, 1'b1, 16'hFF00, 16'h0000, 3'd2, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 9'd511},
    '{8'h05, 1'b1, 16'hDF00, 16'h0000, 3'd1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 9'd479},
    '{8'h0B, 1'b0, 16'h0500, 16'h0000, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 9'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_csr(input logic [7:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic strobe_after(input int d);
    for (int i = 1; i < d; i++) @(negedge clk);
    spm_strobe = 1'b1;
    @(negedge clk);
    spm_strobe = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < OPC + 8; i++) begin
      if (!csr_rdata[0]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    bit seen_done;
    rst_n = 1'b0; csr_we = 1'b0; csr_wdata = '0; zptr = '0; zext = 1'b0;
    data_word = '0; spm_strobe = 1'b0; eep_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(csr_rdata == 8'h00 && !irq && !cpu_halt && !rww_busy && !flash_go && !buf_we,
          "R12", {csr_rdata, irq, cpu_halt, rww_busy, flash_go, buf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      zptr = VEC[k].z; zext = VEC[k].zx; data_word = VEC[k].data;
      write_csr(VEC[k].wdata);
      strobe_after(int'(VEC[k].dly));
      // R3 R5 R11 start pulse and kind
      check(flash_go == VEC[k].go, "R3/R5/R11 go", flash_go, VEC[k].go);
      if (VEC[k].go) begin
        check(flash_kind == VEC[k].kind, "R3 kind", flash_kind, VEC[k].kind);
        if (VEC[k].kind != 2'b11)
          check(flash_page == VEC[k].page, "R3 page", flash_page, VEC[k].page);
        else
          check(lock_bits == VEC[k].data[7:0], "R5 lock", lock_bits, VEC[k].data[7:0]);
      end
      // R4 buffer load
      check(buf_we == VEC[k].bufw, "R4 buf_we", buf_we, VEC[k].bufw);
      if (VEC[k].bufw)
        check(buf_index == VEC[k].z[7:1] && buf_data == VEC[k].data && !csr_rdata[0],
              "R4 buf", {buf_index, buf_data}, {VEC[k].z[7:1], VEC[k].data});
      // R7 halt, R6 busy flag
      check(cpu_halt == VEC[k].halt, "R7 halt", cpu_halt, VEC[k].halt);
      check(rww_busy == VEC[k].rww && csr_rdata[6] == VEC[k].rww, "R6 busy",
            {rww_busy, csr_rdata[6]}, {VEC[k].rww, VEC[k].rww});
      if (!VEC[k].go)
        check(csr_rdata[0] == 1'b0, "R11 enable", csr_rdata[0], 0);
      wait_idle();
      check(cpu_halt == 1'b0, "R7 release", cpu_halt, 0);
      // R6 re-open clears busy
      write_csr(8'h11);
      strobe_after(1);
      check(!rww_busy && csr_rdata[6:0] == 7'h00, "R6 reopen", csr_rdata, 0);
    end

    // R10 operation length
    zptr = 16'h0300; zext = 1'b0;
    write_csr(8'h03);
    strobe_after(1);
    cnt = 0; seen_done = 0;
    while (csr_rdata[0] && cnt < OPC + 8) begin
      if (flash_done) seen_done = 1;
      cnt++;
      @(negedge clk);
    end
    check(cnt == OPC && seen_done, "R10 length", cnt, OPC);
    write_csr(8'h11); strobe_after(1);

    // R1 window expiry timing
    write_csr(8'h05);
    repeat (3) @(negedge clk);
    check(csr_rdata == 8'h05, "R1 open", csr_rdata, 8'h05);
    @(negedge clk);
    check(csr_rdata == 8'h00, "R1 expired", csr_rdata, 0);
    // R11 late strobe
    strobe_after(1);
    check(!flash_go && csr_rdata == 8'h00, "R11 late", {flash_go, csr_rdata}, 0);

    // R2 write without enable drops command bits, R8 interrupt
    write_csr(8'h86);
    check(csr_rdata == 8'h80 && irq, "R2/R8 idle", {csr_rdata, irq}, {8'h80, 1'b1});
    write_csr(8'h81);
    check(!irq, "R8 enabled", irq, 0);
    repeat (4) @(negedge clk);
    check(irq && csr_rdata == 8'h80, "R8 after timeout", {irq, csr_rdata}, {1'b1, 8'h80});

    // R9 eeprom blocks writes
    eep_busy = 1'b1;
    write_csr(8'h03);
    strobe_after(1);
    check(csr_rdata == 8'h80 && !flash_go, "R9", {csr_rdata, flash_go}, {8'h80, 1'b0});
    eep_busy = 1'b0;

    // R11 strobe with enable clear
    strobe_after(1);
    check(!flash_go && !buf_we, "R11 idle strobe", {flash_go, buf_we}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule